// File: doc/BRIEF.md
# Priority Interrupt Request Controller

This block collects interrupt requests from a parameterised set of sources (eight by default) and decides which one the processor should take next. Three registers describe each source: a pending register that records requests raised but not yet acknowledged, an in-service register that records requests acknowledged but not yet ended, and a mask register that hides sources from selection. A single registered interrupt line tells the processor that a request is waiting. The processor then pulses an acknowledge strobe. On the following cycle the block reports whether the acknowledge was granted and which source was chosen, and it moves that source from pending to in service.

Interrupts are ended by one of three methods. A specific end command names the source to clear. A non-specific end command clears the in-service source with the highest current priority. In auto-end mode the acknowledge itself finishes the interrupt. Priority is either fixed, with source 0 highest, or rotating, where a source that has just finished drops to the lowest rank. Each source can be set on its own to detect rising edges or to follow its input level. A small write port loads the mask, the per-source trigger selection and a control word.

Top module: `pic_top`

## Requirements
- R1: After a synchronous reset, pending, in-service, mask and trigger selection are all zero, irq_out and ack_valid are low, and the block starts in fixed priority, edge-triggered, with auto-end off.
- R2: For an edge-triggered source, a 0-to-1 change on its input sets its pending bit at the next clock edge. The bit stays set after the input falls, and only a granted acknowledge of that source clears it.
- R3: For a level-triggered source (trigger bit = 1), the pending bit follows the input sampled at each clock edge. If the input falls before the source is acknowledged, the pending bit clears.
- R4: A source whose mask bit is 1 is never signalled on irq_out and is never granted by an acknowledge. Its pending bit is still recorded, and once the mask bit is cleared the request is signalled at the next edge.
- R5: In fixed priority mode, a lower source index always beats a higher one.
- R6: An acknowledge pulse in a cycle where irq_out is high produces ack_valid = 1 and ack_idx = the selected source in the next cycle. It also sets that source's in-service bit and clears its pending bit. An acknowledge while irq_out is low gives ack_valid = 0 and ack_idx = 0, and changes no state.
- R7: irq_out is high only when an unmasked pending source ranks strictly above every in-service source. A source of equal or lower rank waits until the in-service bit above it clears.
- R8: A specific end command (eoi_valid = 1, eoi_specific = 1) clears only the in-service bit at eoi_idx. If that bit is already clear, nothing changes.
- R9: A non-specific end command (eoi_valid = 1, eoi_specific = 0) clears the highest-priority set bit of the in-service register.
- R10: With auto-end on (control bit 1), a granted acknowledge leaves the in-service register unchanged and still clears the pending bit.
- R11: With rotating priority on (control bit 0), the source whose interrupt just ended becomes the lowest rank, and the source after it in index order becomes the highest.
- R12: Configuration writes use cfg_sel: 0 loads the mask (bit i = 1 masks source i), 1 loads the trigger selection (bit i = 1 means level), and 2 loads the control word (bit 0 = rotating, bit 1 = auto-end). Each write takes effect at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_SRC | Request inputs, one per source |
| ack | input | 1 | Acknowledge strobe from the processor |
| ack_valid | output | 1 | Acknowledge was granted (one cycle after ack) |
| ack_idx | output | IW | Index of the granted source, 0 when not granted |
| irq_out | output | 1 | Interrupt request to the processor |
| eoi_valid | input | 1 | End-of-interrupt command strobe |
| eoi_specific | input | 1 | 1 = clear source eoi_idx, 0 = clear highest in service |
| eoi_idx | input | IW | Source named by a specific end command |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 2 | Configuration target: 0 mask, 1 trigger, 2 control |
| cfg_wdata | input | N_SRC | Configuration write data |
| pending | output | N_SRC | Current pending register |
| in_service | output | N_SRC | Current in-service register |

## Verification
The bench builds the controller with the default N_SRC = 8, so the index width is three bits. With eight sources, rotation wraps from source 7 back to source 0, and a pending source can sit both above and below an in-service one. Eight sources is enough to show nested service (a low index interrupting a high one) and blocked requests in the same sequence. The same width lets the bench walk the rotated order past its starting point and confirm that index 3 beats index 0 after source 1 has finished.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    CFG_MASK = 2'd0,
    CFG_TRIG = 2'd1,
    CFG_CTRL = 2'd2
  } cfg_sel_e;

  localparam int CTRL_ROTATE_BIT = 0;
  localparam int CTRL_AUTO_BIT   = 1;
endpackage

// File: rtl/pic_trigger.sv
module pic_trigger #(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] irq_in,
  input  logic [N_SRC-1:0] level_mode,
  input  logic [N_SRC-1:0] clr,
  output logic [N_SRC-1:0] pend_q,
  output logic [N_SRC-1:0] pend_d
);
  logic [N_SRC-1:0] irq_q;

  generate
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
      always_comb begin
        if (level_mode[i])
          pend_d[i] = irq_in[i] & ~clr[i];
        else
          pend_d[i] = (pend_q[i] & ~clr[i]) | (irq_in[i] & ~irq_q[i]);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q  <= '0;
      pend_q <= '0;
    end else begin
      irq_q  <= irq_in;
      pend_q <= pend_d;
    end
  end

  // a level source whose input was low cannot be pending afterwards
  assert_level_drop_R3: assert property (@(posedge clk) disable iff (rst)
    (($past(level_mode & ~irq_in)) & pend_q) == '0);

  // an edge request survives until it is cleared by an acknowledge
  assert_edge_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (($past(~level_mode & pend_q & ~clr)) & ~pend_q) == '0);
endmodule

// File: rtl/pic_pick.sv
module pic_pick #(
  parameter int N_SRC = 8,
  parameter int IW    = 3
) (
  input  logic [N_SRC-1:0] vec,
  input  logic [IW-1:0]    base,
  output logic             found,
  output logic [IW-1:0]    idx,
  output logic [IW-1:0]    rank
);
  // scan from lowest priority up so the highest-priority hit is kept last
  always_comb begin
    found = 1'b0;
    idx   = '0;
    rank  = '0;
    for (int k = N_SRC - 1; k >= 0; k--) begin
      int j;
      j = int'(base) + k;
      if (j >= N_SRC) j = j - N_SRC;
      if (vec[j]) begin
        found = 1'b1;
        idx   = IW'(j);
        rank  = IW'(k);
      end
    end
  end
endmodule

// File: rtl/pic_top.sv
module pic_top #(
  parameter int N_SRC = 8,
  localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] irq_in,
  input  logic             ack,
  output logic             ack_valid,
  output logic [IW-1:0]    ack_idx,
  output logic             irq_out,
  input  logic             eoi_valid,
  input  logic             eoi_specific,
  input  logic [IW-1:0]    eoi_idx,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [N_SRC-1:0] cfg_wdata,
  output logic [N_SRC-1:0] pending,
  output logic [N_SRC-1:0] in_service
);
  import pic_pkg::*;

  logic [N_SRC-1:0] mask_q, mask_d;
  logic [N_SRC-1:0] trig_q, trig_d;
  logic             rot_q, rot_d;
  logic             auto_q, auto_d;
  logic [N_SRC-1:0] isr_q, isr_d;
  logic [IW-1:0]    base_q, base_d;
  logic             irq_q;
  logic [IW-1:0]    sel_q;
  logic             ackv_q;
  logic [IW-1:0]    acki_q;

  logic             grant;
  logic [N_SRC-1:0] ack_clr;
  logic [N_SRC-1:0] pend_q, pend_d;
  logic [N_SRC-1:0] spec_mask;

  logic [IW-1:0]    base_now, base_nxt;
  logic             top_found;
  logic [IW-1:0]    top_idx, top_rank;
  logic             end_hit;
  logic [IW-1:0]    end_idx;

  logic             p_found, i_found;
  logic [IW-1:0]    p_idx, p_rank, i_idx, i_rank;
  logic             irq_d;

  function automatic logic [IW-1:0] next_idx(input logic [IW-1:0] x);
    return (int'(x) == N_SRC - 1) ? '0 : IW'(int'(x) + 1);
  endfunction

  assign grant     = ack & irq_q;
  assign ack_clr   = grant ? (N_SRC'(1) << sel_q) : '0;
  assign spec_mask = N_SRC'(1) << eoi_idx;

  // configuration next state
  always_comb begin
    mask_d = mask_q;
    trig_d = trig_q;
    rot_d  = rot_q;
    auto_d = auto_q;
    if (cfg_we) begin
      case (cfg_sel_e'(cfg_sel))
        CFG_MASK: mask_d = cfg_wdata;
        CFG_TRIG: trig_d = cfg_wdata;
        CFG_CTRL: begin
          rot_d  = cfg_wdata[CTRL_ROTATE_BIT];
          auto_d = cfg_wdata[CTRL_AUTO_BIT];
        end
        default: ;
      endcase
    end
  end

  pic_trigger #(.N_SRC(N_SRC)) u_trig (
    .clk        (clk),
    .rst        (rst),
    .irq_in     (irq_in),
    .level_mode (trig_q),
    .clr        (ack_clr),
    .pend_q     (pend_q),
    .pend_d     (pend_d)
  );

  assign base_now = rot_q ? base_q : '0;

  pic_pick #(.N_SRC(N_SRC), .IW(IW)) u_isr_now (
    .vec   (isr_q),
    .base  (base_now),
    .found (top_found),
    .idx   (top_idx),
    .rank  (top_rank)
  );

  // end-of-interrupt decode
  always_comb begin
    end_hit = 1'b0;
    end_idx = '0;
    if (eoi_valid) begin
      if (eoi_specific) begin
        end_idx = eoi_idx;
        end_hit = (int'(eoi_idx) < N_SRC) && isr_q[eoi_idx];
      end else begin
        end_idx = top_idx;
        end_hit = top_found;
      end
    end
  end

  // in-service and rotation base next state
  always_comb begin
    isr_d = isr_q;
    if (grant && !auto_q) isr_d[sel_q] = 1'b1;
    if (end_hit)          isr_d[end_idx] = 1'b0;
    base_d = base_q;
    if (rot_q) begin
      if (grant && auto_q) base_d = next_idx(sel_q);
      else if (end_hit)    base_d = next_idx(end_idx);
    end
  end

  assign base_nxt = rot_d ? base_d : '0;

  pic_pick #(.N_SRC(N_SRC), .IW(IW)) u_pend_nxt (
    .vec   (pend_d & ~mask_d),
    .base  (base_nxt),
    .found (p_found),
    .idx   (p_idx),
    .rank  (p_rank)
  );

  pic_pick #(.N_SRC(N_SRC), .IW(IW)) u_isr_nxt (
    .vec   (isr_d),
    .base  (base_nxt),
    .found (i_found),
    .idx   (i_idx),
    .rank  (i_rank)
  );

  assign irq_d = p_found && (!i_found || (p_rank < i_rank));

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      trig_q <= '0;
      rot_q  <= 1'b0;
      auto_q <= 1'b0;
      isr_q  <= '0;
      base_q <= '0;
      irq_q  <= 1'b0;
      sel_q  <= '0;
      ackv_q <= 1'b0;
      acki_q <= '0;
    end else begin
      mask_q <= mask_d;
      trig_q <= trig_d;
      rot_q  <= rot_d;
      auto_q <= auto_d;
      isr_q  <= isr_d;
      base_q <= base_d;
      irq_q  <= irq_d;
      sel_q  <= p_idx;
      ackv_q <= grant;
      if (ack) acki_q <= grant ? sel_q : '0;
    end
  end

  assign irq_out    = irq_q;
  assign ack_valid  = ackv_q;
  assign ack_idx    = acki_q;
  assign pending    = pend_q;
  assign in_service = isr_q;

  assert_mask_block_R4: assert property (@(posedge clk) disable iff (rst)
    grant |-> !mask_q[sel_q]);

  assert_nest_R7: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> !isr_q[sel_q]);

  assert_ack_follows_irq_R6: assert property (@(posedge clk) disable iff (rst)
    ackv_q |-> $past(irq_q && ack));

  assert_auto_no_isr_R10: assert property (@(posedge clk) disable iff (rst)
    (ackv_q && $past(auto_q)) |-> !isr_q[acki_q]);

  assert_spec_eoi_R8: assert property (@(posedge clk) disable iff (rst)
    (eoi_valid && eoi_specific && !ack) |=> (isr_q == ($past(isr_q) & ~$past(spec_mask))));

  assert_nonspec_eoi_R9: assert property (@(posedge clk) disable iff (rst)
    (eoi_valid && !eoi_specific && !ack && (isr_q != '0)) |=>
      ($countones(isr_q) + 1 == $countones($past(isr_q))));
endmodule

// File: tb/pic_top_test.sv
module pic_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int NROWS = 18;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] irq_in;
  logic         ack;
  logic         ack_valid;
  logic [2:0]   ack_idx;
  logic         irq_out;
  logic         eoi_valid;
  logic         eoi_specific;
  logic [2:0]   eoi_idx;
  logic         cfg_we;
  logic [1:0]   cfg_sel;
  logic [N-1:0] cfg_wdata;
  logic [N-1:0] pending;
  logic [N-1:0] in_service;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pic_top #(.N_SRC(N)) uut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .ack(ack),
    .ack_valid(ack_valid), .ack_idx(ack_idx), .irq_out(irq_out),
    .eoi_valid(eoi_valid), .eoi_specific(eoi_specific), .eoi_idx(eoi_idx),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .pending(pending), .in_service(in_service)
  );

  typedef struct packed {
    logic [7:0] irq;
    logic       ack;
    logic       eoi;
    logic       spec;
    logic [2:0] eidx;
    logic       xirq;
    logic       xav;
    logic [2:0] xidx;
    logic [7:0] xisr;
    logic [7:0] xpend;
  } row_t;

  // irq, ack, eoi, spec, eidx | irq_out, ack_valid, ack_idx, in_service, pending
  localparam logic [34:0] TBL [NROWS] = '{
    {8'h00,1'b0,1'b0,1'b0,3'd0, 1'b0,1'b0,3'd0, 8'h00,8'h00},
    {8'h20,1'b0,1'b0,1'b0,3'd0, 1'b1,1'b0,3'd0, 8'h00,8'h20},
    {8'h00,1'b0,1'b0,1'b0,3'd0, 1'b1,1'b0,3'd0, 8'h00,8'h20},
    {8'h00,1'b1,1'b0,1'b0,3'd0, 1'b0,1'b1,3'd5, 8'h20,8'h00},
    {8'h80,1'b0,1'b0,1'b0,3'd0, 1'b0,1'b0,3'd0, 8'h20,8'h80},
    {8'h84,1'b0,1'b0,1'b0,3'd0, 1'b1,1'b0,3'd0, 8'h20,8'h84},
    {8'h84,1'b1,1'b0,1'b0,3'd0, 1'b0,1'b1,3'd2, 8'h24,8'h80},
    {8'h84,1'b0,1'b1,1'b0,3'd0, 1'b0,1'b0,3'd0, 8'h20,8'h80},
    {8'h84,1'b0,1'b1,1'b1,3'd6, 1'b0,1'b0,3'd0, 8'h20,8'h80},
    {8'h84,1'b0,1'b1,1'b1,3'd5, 1'b1,1'b0,3'd0, 8'h00,8'h80},
    {8'h00,1'b1,1'b0,1'b0,3'd0, 1'b0,1'b1,3'd7, 8'h80,8'h00},
    {8'h00,1'b0,1'b1,1'b1,3'd7, 1'b0,1'b0,3'd0, 8'h00,8'h00},
    {8'h00,1'b1,1'b0,1'b0,3'd0, 1'b0,1'b0,3'd0, 8'h00,8'h00},
    {8'h03,1'b0,1'b0,1'b0,3'd0, 1'b1,1'b0,3'd0, 8'h00,8'h03},
    {8'h03,1'b1,1'b0,1'b0,3'd0, 1'b0,1'b1,3'd0, 8'h01,8'h02},
    {8'h03,1'b0,1'b1,1'b0,3'd0, 1'b1,1'b0,3'd0, 8'h00,8'h02},
    {8'h03,1'b1,1'b0,1'b0,3'd0, 1'b0,1'b1,3'd1, 8'h02,8'h00},
    {8'h03,1'b0,1'b1,1'b0,3'd0, 1'b0,1'b0,3'd0, 8'h00,8'h00}
  };

  string row_tag [NROWS] = '{"R1","R2","R2","R6","R7","R7","R6","R9","R8",
                             "R8","R6","R8","R6","R5","R5","R9","R5","R9"};

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    ack = 1'b0; eoi_valid = 1'b0; eoi_specific = 1'b0; eoi_idx = '0;
    cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
  endtask

  task automatic do_reset();
    rst = 1'b1; irq_in = '0; idle_inputs();
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [7:0] data);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    tick();
    idle_inputs();
  endtask

  task automatic pulse_ack();
    ack = 1'b1;
    tick();
    ack = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    // R1: reset state
    chk("R1", "irq_out", irq_out, 0);
    chk("R1", "ack_valid", ack_valid, 0);
    chk("R1", "pending", pending, 0);
    chk("R1", "in_service", in_service, 0);

    // vector table, fixed priority, edge mode
    for (int r = 0; r < NROWS; r++) begin
      row_t v;
      v = row_t'(TBL[r]);
      irq_in = v.irq; ack = v.ack; eoi_valid = v.eoi;
      eoi_specific = v.spec; eoi_idx = v.eidx;
      tick();
      chk(row_tag[r], "irq_out", irq_out, v.xirq);
      chk(row_tag[r], "ack_valid", ack_valid, v.xav);
      if (v.ack) chk(row_tag[r], "ack_idx", ack_idx, v.xidx);
      chk(row_tag[r], "in_service", in_service, v.xisr);
      chk(row_tag[r], "pending", pending, v.xpend);
    end
    idle_inputs();

    // R4 R12: masked source recorded but never signalled or granted
    do_reset();
    cfg_write(2'd0, 8'h08);
    irq_in = 8'h08; tick();
    chk("R4", "pending masked", pending, 8'h08);
    chk("R4", "irq_out masked", irq_out, 0);
    pulse_ack();
    chk("R4", "ack_valid masked", ack_valid, 0);
    chk("R4", "in_service masked", in_service, 0);
    cfg_write(2'd0, 8'h00);
    chk("R12 R4", "irq_out after unmask", irq_out, 1);

    // R3: level trigger follows the input
    do_reset();
    cfg_write(2'd1, 8'h10);
    irq_in = 8'h10; tick();
    chk("R3", "pending level high", pending, 8'h10);
    chk("R3", "irq_out level high", irq_out, 1);
    irq_in = 8'h00; tick();
    chk("R3", "pending level drop", pending, 8'h00);
    chk("R3", "irq_out level drop", irq_out, 0);

    // R10: auto end leaves nothing in service
    do_reset();
    cfg_write(2'd2, 8'h02);
    irq_in = 8'h40; tick();
    chk("R10", "irq_out", irq_out, 1);
    pulse_ack();
    chk("R10", "ack_valid", ack_valid, 1);
    chk("R10", "ack_idx", ack_idx, 6);
    chk("R10", "in_service", in_service, 0);
    chk("R10", "pending", pending, 0);

    // R11: rotating priority moves the finished source to the bottom
    do_reset();
    cfg_write(2'd2, 8'h01);
    irq_in = 8'h02; tick();
    pulse_ack();
    chk("R11", "first ack_idx", ack_idx, 1);
    eoi_valid = 1'b1; eoi_specific = 1'b1; eoi_idx = 3'd1; tick();
    idle_inputs();
    chk("R11", "in_service cleared", in_service, 0);
    irq_in = 8'h0B; tick();
    chk("R11", "irq_out", irq_out, 1);
    pulse_ack();
    chk("R11", "rotated winner", ack_idx, 3);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule